// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. Its transmitter and receiver run at the same time and share one bit-rate divider and one frame configuration. The configuration sets the character length, the stop length, the parity or multi-drop address bit, the bit order, the oversampling ratio and the test mode. It also covers break sending and break detection, RTS/CTS flow control, an idle time-out on the receiver, a guard gap between transmitted characters, and a driver-enable output for an RS485 transceiver.

Software writes the configuration and the transmit characters through a small write port with four addresses:

| Address | Content |
|---|---|
| 0 | mode word |
| 1 | divisor |
| 2 | guard count in bits [7:0], time-out count in bits [15:8] |
| 3 | transmit character, data in bits [8:0], address mark in bit 9 |

The last received character is held on `rx_data`, and its status flags sit next to it. A one-cycle `rd_en` pulse marks the character as read.

The mode word packs these fields:

| Bits | Field | Values |
|---|---|---|
| [3:0] | data bits | values below 5 clamp to 5, values above 9 clamp to 9 |
| [5:4] | stop length | 0 = 1 bit, 1 = 1.5 bits, 2 = 2 bits |
| [7:6] | parity | 0 = none, 1 = even, 2 = odd |
| [8] | bit order | 1 = most significant bit first |
| [9] | oversampling | 1 = x8, 0 = x16 |
| [10] | flow control | 1 = enabled |
| [11] | multi-drop | 1 = enabled |
| [13:12] | test mode | 0 = normal, 1 = automatic echo, 2 = local loopback, 3 = remote loopback |
| [14] | break | 1 = send break |

Top module: `async_xcvr`

## Requirements
- R1: A transmitted frame is one low start bit, then the data bits (5 to 9, from mode bits [3:0]), then the optional extra bit, then a high stop. The line rests high when there is nothing to send. Data goes out least significant bit first unless mode bit 8 is set.
- R2: Mode bits [5:4] set the stop length: 0 gives 1 bit time, 1 gives 1.5 bit times and 2 gives 2 bit times. Characters sent back to back therefore have their start edges (1 + data + extra) bit times plus the stop length apart.
- R3: Mode bits [7:6] select the parity: 0 none, 1 even, 2 odd. The parity bit follows the data on transmit. On receive, a parity mismatch sets `err_parity` for that character.
- R4: `err_frame` is set for a character whose stop bit samples low. `err_overrun` is set and held when a character completes while `rx_ready` is still set. `rd_en` clears `rx_ready`. A write to address 0 clears `err_overrun`, `rx_break` and `rx_timeout`.
- R5: When mode bit 8 is set, data is sent and received most significant bit first.
- R6: One bit period lasts (divisor + 1) × OS clock cycles. OS is 8 when mode bit 9 is set and 16 otherwise.
- R7: While mode bit 14 is set, `txd` is held low. A received frame that is low throughout, stop bit included, sets `rx_break` and delivers no character.
- R8: With flow control on (mode bit 10), no character starts while `cts_n` is high, and `rts_n` is high while an unread character is held. With flow control off, `rts_n` stays low.
- R9: When the time-out count (address 2, bits [15:8]) is nonzero, `rx_timeout` is set after that many idle bit periods following the stop-bit sample of a received character. No new start bit may arrive in that time.
- R10: The guard count (address 2, bits [7:0]) adds that many idle bit periods after each stop bit before the next start.
- R11: With multi-drop on (mode bit 11), the extra bit is the address mark (bit 9 of the transmit write) in place of parity. The receiver reports it on `rx_addr`.
- R12: In automatic echo (mode value 1), `rxd` is driven out on `txd` and still received. In local loopback (2), the transmitter feeds the receiver and `txd` stays high. In remote loopback (3), `rxd` is driven out on `txd` and nothing is received.
- R13: `de` is high from the start bit through the stop bit of each transmitted character, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | write strobe |
| wr_addr | input | 2 | write address |
| wr_data | input | 16 | write data |
| rd_en | input | 1 | marks the received character as read |
| rx_data | output | 9 | last received character |
| rx_addr | output | 1 | address mark of the last character |
| rx_ready | output | 1 | unread character held |
| tx_ready | output | 1 | transmit holding slot empty |
| err_parity | output | 1 | parity mismatch on the last character |
| err_frame | output | 1 | low stop bit on the last character |
| err_overrun | output | 1 | character lost, held until cleared |
| rx_break | output | 1 | break received, held until cleared |
| rx_timeout | output | 1 | idle time-out, held until cleared |
| txd | output | 1 | serial transmit pin |
| rxd | input | 1 | serial receive pin |
| rts_n | output | 1 | request to send, active low |
| cts_n | input | 1 | clear to send, active low |
| de | output | 1 | RS485 driver enable |

## Verification
The bench uses the default divider width of 16 and programs a divisor of 1. That makes a bit period 32 clocks at x16 and 16 clocks at x8, so the frames, the stop lengths, the guard gaps and the time-outs all fit in a few hundred cycles each. Stop length and guard time are measured exactly, as start-edge to start-edge distances between back-to-back all-ones characters. The guard and time-out counts are kept small (2 and 4) so that those windows can be checked on both sides of their edges.

// File: rtl/async_xcvr.sv
module async_xcvr #(
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  output logic [8:0]  rx_data,
  output logic        rx_addr,
  output logic        rx_ready,
  output logic        tx_ready,
  output logic        err_parity,
  output logic        err_frame,
  output logic        err_overrun,
  output logic        rx_break,
  output logic        rx_timeout,
  output logic        txd,
  input  logic        rxd,
  output logic        rts_n,
  input  logic        cts_n,
  output logic        de
);
  localparam logic [2:0] P_IDLE = 3'd0, P_START = 3'd1, P_DATA = 3'd2, P_STOP = 3'd3, P_GUARD = 3'd4;

  logic [14:0] mode;
  logic [DIV_W-1:0] div, div_cnt;
  logic [7:0] guard, tmo;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= 15'h0008; div <= '0; guard <= '0; tmo <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: mode <= wr_data[14:0];
        2'd1: div <= wr_data[DIV_W-1:0];
        2'd2: begin guard <= wr_data[7:0]; tmo <= wr_data[15:8]; end
        default: ;
      endcase
    end

  wire [3:0] len   = (mode[3:0] < 4'd5) ? 4'd5 : (mode[3:0] > 4'd9) ? 4'd9 : mode[3:0];
  wire [1:0] stop  = mode[5:4];
  wire [1:0] par   = mode[7:6];
  wire       msbf  = mode[8];
  wire       flow  = mode[10];
  wire       mdrop = mode[11];
  wire [1:0] tmode = mode[13:12];
  wire       brk   = mode[14];
  wire [12:0] osn  = mode[9] ? 13'd8 : 13'd16;
  wire [3:0] nbits = len + {3'd0, mdrop || (par != 2'd0)};

  wire tick = (div_cnt == div);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else div_cnt <= tick ? '0 : div_cnt + 1'b1;

  // transmitter
  logic [2:0] tx_ph;
  logic [3:0] tx_k, tx_nk;
  logic [12:0] tx_tk, tx_lim;
  logic [9:0] tx_word, tx_buf;
  logic [8:0] tx_dm;
  logic tx_line, tx_pend, tx_nb;

  wire tx_go  = tx_pend && (!flow || !cts_n);
  wire tx_end = (tx_ph == P_IDLE) || (tx_ph == P_GUARD) || (tx_ph == P_STOP && guard == 8'd0);
  assign tx_nk = (tx_ph == P_START) ? 4'd0 : tx_k + 4'd1;

  always_comb begin
    tx_dm = tx_word[8:0] & ~(9'h1FF << len);
    if (tx_nk < len) tx_nb = msbf ? tx_dm[len - 4'd1 - tx_nk] : tx_dm[tx_nk];
    else tx_nb = mdrop ? tx_word[9] : ((par == 2'd2) ^ (^tx_dm));
    case (tx_ph)
      P_STOP:  tx_lim = (stop == 2'd0) ? osn : (stop == 2'd1) ? osn + (osn >> 1) : osn << 1;
      P_GUARD: tx_lim = {5'd0, guard} * osn;
      default: tx_lim = osn;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_ph <= P_IDLE; tx_k <= '0; tx_tk <= '0; tx_line <= 1'b1;
      tx_word <= '0; tx_buf <= '0; tx_pend <= 1'b0;
    end else begin
      if (tick) begin
        if (tx_ph != P_IDLE && tx_tk != tx_lim - 13'd1) tx_tk <= tx_tk + 13'd1;
        else begin
          tx_tk <= '0;
          if (tx_end) begin
            if (tx_go) begin
              tx_ph <= P_START; tx_word <= tx_buf; tx_pend <= 1'b0; tx_line <= 1'b0; tx_k <= '0;
            end else begin
              tx_ph <= P_IDLE; tx_line <= 1'b1;
            end
          end else if (tx_ph == P_STOP) tx_ph <= P_GUARD;
          else if (tx_ph == P_DATA && tx_k == nbits - 4'd1) begin
            tx_ph <= P_STOP; tx_line <= 1'b1;
          end else begin
            tx_ph <= P_DATA; tx_k <= tx_nk; tx_line <= tx_nb;
          end
        end
      end
      if (wr_en && wr_addr == 2'd3) begin tx_buf <= wr_data[9:0]; tx_pend <= 1'b1; end
    end

  wire tx_out = brk ? 1'b0 : tx_line;
  assign tx_ready = !tx_pend;
  assign de  = (tx_ph == P_START) || (tx_ph == P_DATA) || (tx_ph == P_STOP);
  assign txd = (tmode == 2'd0) ? tx_out : (tmode == 2'd2) ? 1'b1 : rxd;

  // receiver
  logic rs1, rs2, armed, tmo_on, rx_one, rx_x;
  logic [2:0] rx_ph;
  logic [3:0] rx_k;
  logic [12:0] rx_tk;
  logic [8:0] rx_d;
  logic [7:0] tcnt;
  wire rx_src = (tmode == 2'd2) ? tx_out : (tmode == 2'd3) ? 1'b1 : rs2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rs1 <= 1'b1; rs2 <= 1'b1; armed <= 1'b0; tmo_on <= 1'b0; rx_one <= 1'b0; rx_x <= 1'b0;
      rx_ph <= P_IDLE; rx_k <= '0; rx_tk <= '0; rx_d <= '0; tcnt <= '0;
      rx_data <= '0; rx_addr <= 1'b0; rx_ready <= 1'b0; err_parity <= 1'b0; err_frame <= 1'b0;
      err_overrun <= 1'b0; rx_break <= 1'b0; rx_timeout <= 1'b0;
    end else begin
      rs1 <= rxd; rs2 <= rs1;
      if (wr_en && wr_addr == 2'd0) begin err_overrun <= 1'b0; rx_break <= 1'b0; rx_timeout <= 1'b0; end
      if (rd_en) rx_ready <= 1'b0;
      if (tick) case (rx_ph)
        P_IDLE:
          if (armed && !rx_src) begin rx_ph <= P_START; rx_tk <= '0; tmo_on <= 1'b0; end
          else begin
            if (rx_src) armed <= 1'b1;
            if (tmo_on) begin
              if (rx_tk == osn - 13'd1) begin
                rx_tk <= '0; tcnt <= tcnt + 8'd1;
                if (tcnt + 8'd1 == tmo) begin rx_timeout <= 1'b1; tmo_on <= 1'b0; end
              end else rx_tk <= rx_tk + 13'd1;
            end
          end
        P_START:
          if (rx_tk == (osn >> 1) - 13'd1) begin
            rx_tk <= '0;
            if (rx_src) rx_ph <= P_IDLE;
            else begin rx_ph <= P_DATA; rx_k <= '0; rx_d <= '0; rx_one <= 1'b0; end
          end else rx_tk <= rx_tk + 13'd1;
        P_DATA:
          if (rx_tk == osn - 13'd1) begin
            rx_tk <= '0; rx_one <= rx_one | rx_src;
            if (rx_k < len) rx_d[msbf ? len - 4'd1 - rx_k : rx_k] <= rx_src;
            else rx_x <= rx_src;
            if (rx_k == nbits - 4'd1) rx_ph <= P_STOP; else rx_k <= rx_k + 4'd1;
          end else rx_tk <= rx_tk + 13'd1;
        default:
          if (rx_tk == osn - 13'd1) begin
            rx_tk <= '0; rx_ph <= P_IDLE; armed <= 1'b0; tcnt <= '0; tmo_on <= (tmo != 8'd0);
            if (!rx_one && !rx_src) rx_break <= 1'b1;
            else begin
              rx_data <= rx_d; rx_addr <= mdrop & rx_x; err_frame <= !rx_src;
              err_parity <= !mdrop && (par != 2'd0) && (rx_x != ((par == 2'd2) ^ (^rx_d)));
              if (rx_ready && !rd_en) err_overrun <= 1'b1;
              rx_ready <= 1'b1;
            end
          end else rx_tk <= rx_tk + 13'd1;
      endcase
    end

  assign rts_n = flow && rx_ready;

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ph == P_IDLE) |-> tx_line);
  assert_cts_gates_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flow && $rose(de)) |-> $past(!cts_n));
  assert_ready_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(rd_en));
  assert_overrun_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(rx_ready));
  assert_timeout_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_timeout) |-> (rx_ph == P_IDLE));
  assert_de_needs_char_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de) |-> $past(tx_pend));
endmodule

// File: tb/async_xcvr_bench.sv
module async_xcvr_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic wr_en = 0, rd_en = 0, rxd = 1, cts_n = 0;
  logic [1:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [8:0] rx_data;
  logic rx_addr, rx_ready, tx_ready, err_parity, err_frame, err_overrun, rx_break, rx_timeout;
  logic txd, rts_n, de;
  int n_chk = 0, n_bad = 0;

  async_xcvr u_async_xcvr (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_en, .rx_data, .rx_addr,
    .rx_ready, .tx_ready, .err_parity, .err_frame, .err_overrun, .rx_break, .rx_timeout,
    .txd, .rxd, .rts_n, .cts_n, .de);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin n_bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd();
    @(negedge clk); rd_en = 1; @(negedge clk); rd_en = 0;
  endtask

  function automatic logic [15:0] mw(int ln, int st, int pr, int msb, int os8, int fl, int md, int tm, int bk);
    return 16'(ln | (st << 4) | (pr << 6) | (msb << 8) | (os8 << 9) | (fl << 10) | (md << 11) | (tm << 12) | (bk << 14));
  endfunction

  // frame in line order at index 0..n-1: start, data, extra, stop
  function automatic logic [15:0] fr(logic [8:0] d, int ln, int msb, int xen, logic x);
    logic [15:0] f = 0;
    for (int i = 0; i < ln; i++) f[1+i] = msb ? d[ln-1-i] : d[i];
    if (xen) f[1+ln] = x;
    f[1+ln+xen] = 1'b1;
    return f;
  endfunction

  function automatic logic par_of(logic [8:0] d, int ln, int odd);
    int c = 0;
    for (int i = 0; i < ln; i++) c += d[i];
    return logic'((c + odd) % 2);
  endfunction

  task automatic drive(input logic [15:0] f, input int n, input int bp);
    for (int i = 0; i < n; i++) begin rxd = f[i]; repeat (bp) @(negedge clk); end
    rxd = 1;
  endtask

  task automatic grab(output logic [15:0] f, input int n, input int bp, output logic de_mid);
    f = 0;
    while (txd !== 1'b0) @(negedge clk);
    repeat (bp/2) @(negedge clk);
    de_mid = de;
    for (int i = 0; i < n; i++) begin f[i] = txd; if (i < n-1) repeat (bp) @(negedge clk); end
  endtask

  task automatic gap(output int c);
    c = 0;
    while (txd !== 1'b0) @(negedge clk);
    while (txd !== 1'b1) begin @(negedge clk); c++; end
    while (txd !== 1'b0) begin @(negedge clk); c++; end
  endtask

  task automatic t_reset();
    chk("R1 reset txd", txd, 1);
    chk("R4 reset rx_ready", rx_ready, 0);
    chk("R13 reset de", de, 0);
    chk("R8 reset rts_n", rts_n, 0);
    chk("R4 reset flags", {err_parity, err_frame, err_overrun, rx_break, rx_timeout}, 0);
    chk("R1 reset tx_ready", tx_ready, 1);
  endtask

  task automatic t_tx_frames();
    logic [15:0] f; logic dm;
    wr(1, 1); wr(0, mw(8,0,0,0,0,0,0,0,0));
    wr(3, 16'h0A5); grab(f, 10, 32, dm);
    chk("R1 R6 tx 8N1 x16", f, fr(9'h0A5, 8, 0, 0, 0));
    chk("R13 de during frame", dm, 1);
    repeat (40) @(negedge clk);
    chk("R13 de after frame", de, 0);
    wr(0, mw(5,0,0,1,1,0,0,0,0));
    wr(3, 16'h013); grab(f, 7, 16, dm);
    chk("R5 R6 tx 5-bit msb-first x8", f, fr(9'h013, 5, 1, 0, 0));
    repeat (40) @(negedge clk);
    wr(0, mw(7,0,1,0,0,0,0,0,0));
    wr(3, 16'h055); grab(f, 10, 32, dm);
    chk("R3 tx even parity", f, fr(9'h055, 7, 0, 1, par_of(9'h055, 7, 0)));
    repeat (60) @(negedge clk);
    wr(0, mw(9,0,2,0,0,0,0,0,0));
    wr(3, 16'h155); grab(f, 12, 32, dm);
    chk("R1 R3 tx 9-bit odd parity", f, fr(9'h155, 9, 0, 1, par_of(9'h155, 9, 1)));
    repeat (60) @(negedge clk);
    wr(0, mw(8,0,0,0,0,0,1,0,0));
    wr(3, 16'h242); grab(f, 11, 32, dm);
    chk("R11 tx address mark", f, fr(9'h042, 8, 0, 1, 1));
    repeat (60) @(negedge clk);
  endtask

  task automatic t_spacing(input int st, input int gd, input int exp, input string tag);
    int c;
    wr(0, mw(8,st,0,0,0,0,0,0,0)); wr(2, 16'(gd));
    fork
      gap(c);
      begin wr(3, 16'h0FF); wait (tx_ready == 1'b0); wait (tx_ready == 1'b1); wr(3, 16'h0FF); end
    join
    chk(tag, c, exp);
    repeat (500) @(negedge clk);
    wr(2, 0);
  endtask

  task automatic t_break();
    logic low = 1;
    wr(0, mw(8,0,0,0,0,0,0,0,1));
    for (int i = 0; i < 64; i++) begin @(negedge clk); if (txd !== 1'b0) low = 0; end
    chk("R7 break holds txd low", low, 1);
    wr(0, mw(8,0,0,0,0,0,0,0,0));
    @(negedge clk);
    chk("R7 break released", txd, 1);
    drive(16'h0000, 12, 32); repeat (4) @(negedge clk);
    chk("R7 break detected", rx_break, 1);
    chk("R7 break gives no char", rx_ready, 0);
    wr(0, mw(8,0,0,0,0,0,0,0,0));
    chk("R4 sticky cleared by mode write", rx_break, 0);
  endtask

  task automatic t_rx();
    wr(0, mw(8,0,0,0,0,0,0,0,0));
    drive(fr(9'h03C, 8, 0, 0, 0), 10, 32); repeat (4) @(negedge clk);
    chk("R1 rx ready", rx_ready, 1);
    chk("R1 rx data", rx_data, 9'h03C);
    chk("R4 no frame error", err_frame, 0);
    rd();
    chk("R4 rd clears ready", rx_ready, 0);
    wr(0, mw(6,0,0,1,1,0,0,0,0));
    drive(fr(9'h029, 6, 1, 0, 0), 8, 16); repeat (4) @(negedge clk);
    chk("R5 rx msb-first x8", rx_data, 9'h029);
    rd();
    wr(0, mw(8,0,2,0,0,0,0,0,0));
    drive(fr(9'h0B1, 8, 0, 1, ~par_of(9'h0B1, 8, 1)), 11, 32); repeat (4) @(negedge clk);
    chk("R3 parity mismatch flagged", err_parity, 1);
    rd();
    drive(fr(9'h0B1, 8, 0, 1, par_of(9'h0B1, 8, 1)), 11, 32); repeat (4) @(negedge clk);
    chk("R3 good parity clean", err_parity, 0);
    rd();
    wr(0, mw(8,0,0,0,0,0,0,0,0));
    drive(16'h00F2, 10, 32); repeat (40) @(negedge clk);
    chk("R4 framing error", err_frame, 1);
    rd();
    drive(fr(9'h011, 8, 0, 0, 0), 10, 32); repeat (4) @(negedge clk);
    chk("R4 frame error clears", err_frame, 0);
    drive(fr(9'h022, 8, 0, 0, 0), 10, 32); repeat (4) @(negedge clk);
    chk("R4 overrun set", err_overrun, 1);
    chk("R4 overrun newest data", rx_data, 9'h022);
    rd();
    wr(0, mw(8,0,0,0,0,0,1,0,0));
    chk("R4 overrun cleared", err_overrun, 0);
    drive(fr(9'h07E, 8, 0, 1, 1), 11, 32); repeat (4) @(negedge clk);
    chk("R11 rx address mark", rx_addr, 1);
    chk("R11 rx address data", rx_data, 9'h07E);
    rd();
  endtask

  task automatic t_flow();
    logic quiet = 1; logic [15:0] f; logic dm;
    wr(0, mw(8,0,0,0,0,1,0,0,0));
    cts_n = 1;
    wr(3, 16'h0C3);
    for (int i = 0; i < 128; i++) begin @(negedge clk); if (txd !== 1'b1) quiet = 0; end
    chk("R8 held by cts_n", quiet, 1);
    cts_n = 0;
    grab(f, 10, 32, dm);
    chk("R8 sent after cts_n", f, fr(9'h0C3, 8, 0, 0, 0));
    repeat (40) @(negedge clk);
    drive(fr(9'h005, 8, 0, 0, 0), 10, 32); repeat (4) @(negedge clk);
    chk("R8 rts_n high when full", rts_n, 1);
    rd();
    chk("R8 rts_n low after read", rts_n, 0);
  endtask

  task automatic t_timeout();
    wr(0, mw(8,0,0,0,0,0,0,0,0)); wr(2, 16'h0400);
    drive(fr(9'h081, 8, 0, 0, 0), 10, 32);
    repeat (64) @(negedge clk);
    chk("R9 no timeout early", rx_timeout, 0);
    repeat (96) @(negedge clk);
    chk("R9 timeout raised", rx_timeout, 1);
    rd(); wr(2, 0); wr(0, mw(8,0,0,0,0,0,0,0,0));
  endtask

  task automatic t_tests();
    logic quiet = 1;
    wr(0, mw(8,0,0,0,0,0,0,2,0));
    wr(3, 16'h09C);
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (txd !== 1'b1) quiet = 0; end
    chk("R12 local loop txd idle", quiet, 1);
    chk("R12 local loop data", rx_data, 9'h09C);
    rd();
    wr(0, mw(8,0,0,0,0,0,0,3,0));
    rxd = 0; #1; chk("R12 remote txd follows low", txd, 0);
    rxd = 1; #1; chk("R12 remote txd follows high", txd, 1);
    drive(fr(9'h033, 8, 0, 0, 0), 10, 32); repeat (4) @(negedge clk);
    chk("R12 remote receives nothing", rx_ready, 0);
    wr(0, mw(8,0,0,0,0,0,0,1,0));
    rxd = 0; #1; chk("R12 echo txd follows", txd, 0);
    rxd = 1; repeat (40) @(negedge clk);
    drive(fr(9'h066, 8, 0, 0, 0), 10, 32); repeat (4) @(negedge clk);
    chk("R12 echo still receives", rx_data, 9'h066);
    rd();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_frames();
    t_spacing(0, 0, 320, "R2 one stop spacing");
    t_spacing(1, 0, 336, "R2 1.5 stop spacing");
    t_spacing(2, 0, 352, "R2 two stop spacing");
    t_spacing(0, 2, 384, "R10 guard spacing");
    t_break();
    t_rx();
    t_flow();
    t_timeout();
    t_tests();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule